// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel position inside a two-dimensional tiled container into the system address that reaches that pixel through one of eight rotated or mirrored views. A request carries a pixel format (8-bit, 16-bit or 32-bit tiled, or page mode), a view code and the X/Y coordinates. The result carries the address, a flag for coordinates outside the container, and the line stride of the chosen view. Display and capture engines use it to walk a surface in rotated order without touching the memory layout.

Each format leaves a fixed number of low X and Y coordinate bits unused. This narrows the usable coordinate ranges, and the packed index is then shifted back up by the same total. The view code can invert X, invert Y and swap the axes. The format and view codes are written into the top five address bits.

Requests enter and results leave over valid/ready handshakes. With the default `REGISTERED=1`, one output register sits between them. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the register is empty or is being drained in the same cycle. A result held while `out_ready` is low does not change. With `REGISTERED=0`, the path is combinational: valid and ready pass straight through.

Top module: `tile_view_addr`

## Requirements
- R1: For in-range coordinates, `out_addr[28:27]` equals the format code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is page mode.
- R2: For in-range coordinates, `out_addr[31:29]` equals the view code. In the view code, bit 0 inverts X, bit 1 inverts Y and bit 2 swaps the axes.
- R3: If X exceeds its mask (2^(14-ux)-1) or Y exceeds its mask (2^(13-uy)-1), then `out_bad` is 1 and the whole `out_addr` is 0. Here ux and uy are the format's unused X and Y bit counts.
- R4: When view bit 0 is set, X is XORed with its mask before packing. When view bit 1 is set, Y is XORed with its mask before packing.
- R5: When view bit 2 is clear, the index is (Y << X width) + X. When it is set, the index is (X << Y width) + Y.
- R6: The index is shifted left by ux+uy into `out_addr[26:0]`. The (ux,uy) pairs are (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit.
- R7: Page mode uses ux=uy=6, giving X width 8, Y width 7 and a shift of 12.
- R8: `out_stride` is 2^(13+ux) when the axes are swapped and 2^(14+uy) otherwise. It is produced for in-range and out-of-range coordinates alike.
- R9: `out_valid` is low after reset. It goes high on the clock edge after a request is accepted, and goes low on the edge where a result is taken with no new request.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_fmt | input | 2 | Pixel format code |
| in_view | input | 3 | View code (bit 0 X invert, bit 1 Y invert, bit 2 swap) |
| in_x | input | 16 | Pixel X coordinate |
| in_y | input | 16 | Pixel Y coordinate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 32 | View address |
| out_bad | output | 1 | Coordinate out of range |
| out_stride | output | 32 | Line stride of the view in bytes |

## Verification
The assertions check the following on every cycle:
- the handshake timing (R9, R10);
- that an out-of-range result always carries a zero address;
- that the stride is a single power of two;
- that both code fields follow the accepted request.

The bench's vectors with hand-computed addresses are the only way to show that the inversion, the axis swap, the per-format shifts and the page-mode geometry produce the correct index. The exact mask boundaries, one beyond and at the top, are also shown only by the bench.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef logic [5:0] shamt_t;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } fmt_e;

  typedef struct packed {
    shamt_t ux;   // unused low X bits
    shamt_t uy;   // unused low Y bits
    shamt_t xw;   // usable X width
    shamt_t yw;   // usable Y width
    shamt_t al;   // index shift
  } geom_t;
endpackage

// File: rtl/tva_geom.sv
module tva_geom
  import tva_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 13,
  parameter int PAGE_UX = 6,
  parameter int PAGE_UY = 6
) (
  input  logic [1:0] fmt,
  output geom_t      g
);
  always_comb begin
    g = '0;
    unique case (fmt_e'(fmt))
      FMT_B8:   begin g.ux = 6'd0; g.uy = 6'd0; end
      FMT_B16:  begin g.ux = 6'd0; g.uy = 6'd1; end
      FMT_B32:  begin g.ux = 6'd1; g.uy = 6'd1; end
      default:  begin g.ux = shamt_t'(PAGE_UX); g.uy = shamt_t'(PAGE_UY); end
    endcase
    g.xw = shamt_t'(XW) - g.ux;
    g.yw = shamt_t'(YW) - g.uy;
    g.al = g.ux + g.uy;
  end
endmodule

// File: rtl/tva_map.sv
module tva_map
  import tva_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 13,
  parameter int CW = 16,
  localparam int IDX_W = XW + YW,
  localparam int AW = IDX_W + 5
) (
  input  logic [1:0]    fmt,
  input  logic [2:0]    view,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  geom_t         g,
  output logic [AW-1:0] addr,
  output logic          bad,
  output logic [AW-1:0] stride
);
  logic [AW-1:0] xm, ym, xe, ye, xv, yv, idx, sh;

  always_comb begin
    xm  = ~({AW{1'b1}} << g.xw);
    ym  = ~({AW{1'b1}} << g.yw);
    xe  = AW'(x);
    ye  = AW'(y);
    bad = (xe > xm) || (ye > ym);
    xv  = view[0] ? (xe ^ xm) : xe;
    yv  = view[1] ? (ye ^ ym) : ye;
    idx = view[2] ? ((xv << g.yw) + yv) : ((yv << g.xw) + xv);
    sh  = idx << g.al;
    addr = bad ? '0 : {view, fmt, sh[IDX_W-1:0]};
    stride = view[2] ? (AW'(1) << (shamt_t'(YW) + g.ux))
                     : (AW'(1) << (shamt_t'(XW) + g.uy));
  end
endmodule

// File: rtl/tva_stage.sv
module tva_stage #(
  parameter int DW = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (REGISTERED) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q;
      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_valid && in_ready) begin
          v_q <= 1'b1;
          d_q <= in_data;
        end else if (out_ready) begin
          v_q <= 1'b0;
        end
      end
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/tile_view_addr.sv
module tile_view_addr
  import tva_pkg::*;
#(
  parameter int XW = 14,
  parameter int YW = 13,
  parameter int CW = 16,
  parameter int PAGE_UX = 6,
  parameter int PAGE_UY = 6,
  parameter bit REGISTERED = 1'b1,
  localparam int AW = XW + YW + 5,
  localparam int DW = 2 * AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_fmt,
  input  logic [2:0]    in_view,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_bad,
  output logic [AW-1:0] out_stride
);
  geom_t         geo;
  logic [AW-1:0] c_addr, c_stride;
  logic          c_bad;
  logic [DW-1:0] c_data, q_data;

  tva_geom #(.XW(XW), .YW(YW), .PAGE_UX(PAGE_UX), .PAGE_UY(PAGE_UY)) u_geom (
    .fmt (in_fmt),
    .g   (geo)
  );

  tva_map #(.XW(XW), .YW(YW), .CW(CW)) u_map (
    .fmt    (in_fmt),
    .view   (in_view),
    .x      (in_x),
    .y      (in_y),
    .g      (geo),
    .addr   (c_addr),
    .bad    (c_bad),
    .stride (c_stride)
  );

  assign c_data = {c_addr, c_bad, c_stride};

  tva_stage #(.DW(DW), .REGISTERED(REGISTERED)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (c_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (q_data)
  );

  assign {out_addr, out_bad, out_stride} = q_data;
endmodule

// File: rtl/tile_view_addr_chk.sv
module tile_view_addr_chk #(
  parameter int AW = 32,
  parameter bit REGISTERED = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_fmt,
  input logic [2:0]    in_view,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_bad,
  input logic [AW-1:0] out_stride
);
  a_r3_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_addr == '0);

  a_r8_stride_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_stride) == 1);

  generate
    if (REGISTERED) begin : g_seq
      a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                    && $stable(out_bad) && $stable(out_stride));

      a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

      a_r1_fmt_field: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_bad || out_addr[AW-4:AW-5] == $past(in_fmt));

      a_r2_view_field: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_bad || out_addr[AW-1:AW-3] == $past(in_view));
    end
  endgenerate
endmodule

bind tile_view_addr tile_view_addr_chk #(.AW(AW), .REGISTERED(REGISTERED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_fmt     (in_fmt),
  .in_view    (in_view),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_bad    (out_bad),
  .out_stride (out_stride)
);

// File: tb/test_tile_view_addr.sv
`timescale 1ns/1ps
module test_tile_view_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = '0;
  logic [2:0]  in_view = '0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_bad;
  logic [31:0] out_stride;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tile_view_addr i_tile_view_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_view(in_view), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_bad(out_bad), .out_stride(out_stride)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [2:0]  view;
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] addr;
    logic        bad;
    logic [31:0] stride;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 16'h0005, 16'h0003, 32'h0000C005, 1'b0, 32'h00004000}, // plain 8-bit
    '{2'd1, 3'd0, 16'h0010, 16'h0002, 32'h08010020, 1'b0, 32'h00008000}, // 16-bit shift 1
    '{2'd2, 3'd3, 16'h0000, 16'h0000, 32'h77FFFFFC, 1'b0, 32'h00008000}, // both inverted
    '{2'd0, 3'd4, 16'h0001, 16'h0002, 32'h80002002, 1'b0, 32'h00002000}, // swap
    '{2'd3, 3'd0, 16'h00FF, 16'h007F, 32'h1FFFF000, 1'b0, 32'h00100000}, // page top
    '{2'd3, 3'd0, 16'h0100, 16'h0000, 32'h00000000, 1'b1, 32'h00100000}, // page X over
    '{2'd1, 3'd0, 16'h0000, 16'h1000, 32'h00000000, 1'b1, 32'h00008000}, // 16-bit Y over
    '{2'd0, 3'd1, 16'h3FFF, 16'h0000, 32'h20000000, 1'b0, 32'h00004000}, // X invert
    '{2'd0, 3'd2, 16'h0000, 16'h1FFF, 32'h40000000, 1'b0, 32'h00004000}, // Y invert
    '{2'd2, 3'd6, 16'h0003, 16'h0001, 32'hD000FFF8, 1'b0, 32'h00004000}, // swap + Y inv
    '{2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 32'h07FFFFFF, 1'b0, 32'h00004000}, // mask edge
    '{2'd0, 3'd7, 16'h4000, 16'h0000, 32'h00000000, 1'b1, 32'h00002000}, // 8-bit X over
    '{2'd3, 3'd5, 16'h0002, 16'h0001, 32'hBFE81000, 1'b0, 32'h00080000}  // page swap + X inv
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_fmt  = v.fmt;
    in_view = v.view;
    in_x    = v.x;
    in_y    = v.y;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 out_valid after accept", {31'd0, out_valid}, 32'd1);
      check("R3/R4/R5/R6/R7 address", out_addr, VEC[i].addr);
      check("R3 bad flag", {31'd0, out_bad}, {31'd0, VEC[i].bad});
      check("R8 stride", out_stride, VEC[i].stride);
      if (!VEC[i].bad) begin
        check("R1 format field", {30'd0, out_addr[28:27]}, {30'd0, VEC[i].fmt});
        check("R2 view field", {29'd0, out_addr[31:29]}, {29'd0, VEC[i].view});
      end
      @(negedge clk);
      check("R9 out_valid drains", {31'd0, out_valid}, 32'd0);
    end

    // R10: back-pressure holds the result
    out_ready = 1'b0;
    drive(VEC[0]);
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 in_ready low while held", {31'd0, in_ready}, 32'd0);
    drive(VEC[1]);
    repeat (2) @(negedge clk);
    check("R10 held valid", {31'd0, out_valid}, 32'd1);
    check("R10 held address", out_addr, VEC[0].addr);
    check("R10 held stride", out_stride, VEC[0].stride);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next taken on release", out_addr, VEC[1].addr);
    check("R9 valid stays for new result", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R9 valid falls after drain", {31'd0, out_valid}, 32'd0);

    // R9: reset mid-result clears valid
    drive(VEC[2]);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R9 reset clears valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule